// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This unit turns a CPU-side address that falls in the outbound memory region into a 64-bit bus address. The region is cut into a fixed count of equally sized windows. Each window holds its own translated base (a low and a high 32-bit word) and its own enable, and one global switch turns translation on or off as a whole. A small word-wide register port programs the window size, the per-window words and the global switch, and reads them back.

On the request side, the unit takes an address and a valid strobe. It subtracts the region base, divides the result by the current window size to pick a window, and adds the offset inside that window to the window's 64-bit base. The answer comes back two clock edges later, with a hit flag. The window words sit in two simple dual-port memories, so they can map onto block RAM. The enables live in flip-flops, so that reset can clear them.

Top module: `obx_xlat_top`

## Requirements
- R1: After reset, the control word and the size index read back as 0, every window enable is clear, and every lookup misses.
- R2: A read strobe gives `reg_rvalid` high one cycle later, with the last value written to that register on `reg_rdata`. The size register returns only its 3 stored bits.
- R3: Register offsets: control at 0x004, size index at 0x030 (bits [2:0]), window n low word at 0x200+8n, window n high word at 0x204+8n.
- R4: The window size is 2^N MiB, where N is the size index. The window number is (request address − region base) >> (20+N).
- R5: Translation needs control bit 1. While that bit is 0, every lookup misses.
- R6: Bit 0 of a window's low word enables that window. A lookup that lands on a disabled window misses.
- R7: On a hit, the result is {high word, low word with bit 0 cleared} + (address offset inside the window). The sum is 64 bits wide, with a carry from the low half into the high half.
- R8: An address below the region base, or one whose window number is 32 or more (NUM_WIN), misses.
- R9: A request accepted at one clock edge gives `resp_valid` at the second edge after it. On a miss, `resp_addr` is 0.
- R10: A write to an offset outside the map changes nothing, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | CPU-side address to translate |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Translation hit |
| resp_addr | output | 64 | Translated bus address (0 on miss) |

## Verification
The assertions assume three things about the inputs:
- Register read and write strobes are never high in the same cycle.
- Reset is held long enough to clear the pipeline.
- No window is rewritten in the same cycle that a lookup reads it, because the memories return the old word in that case.

The stimulus drives every input on the falling edge and holds it for one cycle. It finishes each register write before it starts a lookup, so none of these overlaps can occur.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int CTRL_OFS     = 'h004;
  localparam int SIZE_OFS     = 'h030;
  localparam int WIN_BASE_OFS = 'h200;
  localparam int XLAT_EN_BIT  = 1;
  localparam int MB_SHIFT     = 20;
  localparam int WORD_W       = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_SIZE,
    SEL_LO,
    SEL_HI
  } rd_sel_t;
endpackage

// File: rtl/obx_win_ram.sv
module obx_win_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[a_addr] <= wr_data;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/obx_regfile.sv
module obx_regfile
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int REG_AW  = 12,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int SPAN   = 8 * NUM_WIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              xlat_en,
  output logic [2:0]        size_idx,
  output logic [NUM_WIN-1:0] win_en,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              lo_we,
  output logic              hi_we,
  input  logic [WORD_W-1:0] lo_rdata,
  input  logic [WORD_W-1:0] hi_rdata
);
  logic [WORD_W-1:0] ctrl_q;
  logic [2:0]        size_q;
  logic [NUM_WIN-1:0] en_q;
  rd_sel_t           sel_d, sel_q;
  logic              en_bit_q;

  logic [31:0] addr32, rel;
  logic        is_ctrl, is_size, is_win, is_hi;

  always_comb begin
    addr32  = 32'(reg_addr);
    rel     = addr32 - 32'(WIN_BASE_OFS);
    is_ctrl = (addr32 == 32'(CTRL_OFS));
    is_size = (addr32 == 32'(SIZE_OFS));
    is_win  = (addr32 >= 32'(WIN_BASE_OFS)) && (rel < 32'(SPAN)) && (addr32[1:0] == 2'b00);
    is_hi   = rel[2];
    ram_idx = rel[IDX_W+2:3];
    lo_we   = reg_wr_en && is_win && !is_hi;
    hi_we   = reg_wr_en && is_win && is_hi;
    if (is_ctrl)            sel_d = SEL_CTRL;
    else if (is_size)       sel_d = SEL_SIZE;
    else if (is_win && is_hi) sel_d = SEL_HI;
    else if (is_win)        sel_d = SEL_LO;
    else                    sel_d = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      size_q <= '0;
      en_q   <= '0;
    end else if (reg_wr_en) begin
      if (is_ctrl) ctrl_q <= reg_wdata;
      if (is_size) size_q <= reg_wdata[2:0];
      if (lo_we)   en_q[ram_idx] <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      sel_q      <= SEL_NONE;
      en_bit_q   <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd_en;
      if (reg_rd_en) begin
        sel_q    <= sel_d;
        en_bit_q <= en_q[ram_idx];
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_SIZE: reg_rdata = {29'd0, size_q};
      SEL_LO:   reg_rdata = {lo_rdata[WORD_W-1:1], en_bit_q};
      SEL_HI:   reg_rdata = hi_rdata;
      default:  reg_rdata = '0;
    endcase
  end

  assign xlat_en  = ctrl_q[XLAT_EN_BIT];
  assign size_idx = size_q;
  assign win_en   = en_q;

  a_r1_reset_clear: assert property (@(posedge clk) $past(rst) |-> (en_q == '0 && ctrl_q == '0 && size_q == '0));
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst) reg_rd_en |=> reg_rvalid);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst) (reg_rvalid && sel_q == SEL_NONE) |-> reg_rdata == '0);
  a_r10_unmapped_keeps: assert property (@(posedge clk) disable iff (rst) (reg_wr_en && sel_d == SEL_NONE) |=> ($stable(ctrl_q) && $stable(en_q) && $stable(size_q)));
endmodule

// File: rtl/obx_lookup.sv
module obx_lookup
  import obx_pkg::*;
#(
  parameter int NUM_WIN             = 32,
  parameter int ADDR_W              = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h4000_0000,
  localparam int IDX_W              = $clog2(NUM_WIN),
  localparam int OUT_W              = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               xlat_en,
  input  logic [2:0]         size_idx,
  input  logic [NUM_WIN-1:0] win_en,
  output logic [IDX_W-1:0]   ram_idx,
  input  logic [WORD_W-1:0]  lo_word,
  input  logic [WORD_W-1:0]  hi_word,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic [OUT_W-1:0]   resp_addr
);
  logic [ADDR_W-1:0] offs, win_num, mask, inwin;
  logic [5:0]        shift;
  logic              oor;

  always_comb begin
    offs    = req_addr - BASE;
    shift   = 6'(MB_SHIFT) + {3'd0, size_idx};
    win_num = offs >> shift;
    mask    = (ADDR_W'(1) << shift) - ADDR_W'(1);
    inwin   = offs & mask;
    oor     = (req_addr < BASE) || (win_num >= ADDR_W'(NUM_WIN));
    ram_idx = win_num[IDX_W-1:0];
  end

  logic              s1_valid, s1_ok;
  logic [ADDR_W-1:0] s1_inwin;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_ok    <= 1'b0;
      s1_inwin <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_ok    <= !oor && xlat_en && win_en[ram_idx];
      s1_inwin <= inwin;
    end
  end

  logic [OUT_W-1:0] base64;
  assign base64 = {hi_word, lo_word[WORD_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_addr  <= '0;
    end else begin
      resp_valid <= s1_valid;
      resp_hit   <= s1_valid && s1_ok;
      resp_addr  <= (s1_valid && s1_ok) ? base64 + OUT_W'(s1_inwin) : '0;
    end
  end

  a_r9_stage_one: assert property (@(posedge clk) disable iff (rst) req_valid |=> s1_valid);
  a_r9_stage_two: assert property (@(posedge clk) disable iff (rst) s1_valid |=> resp_valid);
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst) (resp_valid && !resp_hit) |-> resp_addr == '0);
  a_r5_global_off: assert property (@(posedge clk) disable iff (rst) (req_valid && !xlat_en) |=> !s1_ok);
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (rst) (req_valid && oor) |=> !s1_ok);
  a_r6_hit_needs_valid: assert property (@(posedge clk) disable iff (rst) resp_hit |-> resp_valid);
endmodule

// File: rtl/obx_xlat_top.sv
module obx_xlat_top
  import obx_pkg::*;
#(
  parameter int NUM_WIN             = 32,
  parameter int ADDR_W              = 32,
  parameter int REG_AW              = 12,
  parameter logic [ADDR_W-1:0] BASE = 32'h4000_0000,
  localparam int IDX_W              = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [63:0]       resp_addr
);
  logic               xlat_en;
  logic [2:0]         size_idx;
  logic [NUM_WIN-1:0] win_en;
  logic [IDX_W-1:0]   reg_idx, req_idx;
  logic               lo_we, hi_we;
  logic [31:0]        lo_a, hi_a, lo_b, hi_b;

  obx_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .xlat_en(xlat_en), .size_idx(size_idx), .win_en(win_en),
    .ram_idx(reg_idx), .lo_we(lo_we), .hi_we(hi_we),
    .lo_rdata(lo_a), .hi_rdata(hi_a)
  );

  obx_win_ram #(.W(32), .DEPTH(NUM_WIN)) u_lo_ram (
    .clk(clk), .wr_en(lo_we), .a_addr(reg_idx), .wr_data(reg_wdata),
    .a_rdata(lo_a), .b_addr(req_idx), .b_rdata(lo_b)
  );

  obx_win_ram #(.W(32), .DEPTH(NUM_WIN)) u_hi_ram (
    .clk(clk), .wr_en(hi_we), .a_addr(reg_idx), .wr_data(reg_wdata),
    .a_rdata(hi_a), .b_addr(req_idx), .b_rdata(hi_b)
  );

  obx_lookup #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .BASE(BASE)) u_lookup (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr),
    .xlat_en(xlat_en), .size_idx(size_idx), .win_en(win_en),
    .ram_idx(req_idx), .lo_word(lo_b), .hi_word(hi_b),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_addr(resp_addr)
  );
endmodule

// File: tb/obx_xlat_top_tb.sv
module obx_xlat_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        resp_valid, resp_hit;
  logic [63:0] resp_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obx_xlat_top u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_addr(resp_addr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic xl(logic [31:0] a, output logic v, output logic h, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    v = resp_valid; h = resp_hit; r = resp_addr;
  endtask

  function automatic logic [11:0] lo_of(int n); return 12'('h200 + 8*n); endfunction
  function automatic logic [11:0] hi_of(int n); return 12'('h204 + 8*n); endfunction

  task automatic t_reset;
    logic [31:0] d; logic v, h; logic [63:0] r;
    rd(12'h004, d, v); check("R1 ctrl after reset", 64'(d), 64'h0);
    rd(12'h030, d, v); check("R1 size after reset", 64'(d), 64'h0);
    rd(lo_of(0), d, v); check("R1 window0 enable after reset", 64'(d[0]), 64'h0);
    wr(12'h004, 32'h2);
    xl(BASE + 32'h10, v, h, r);
    check("R1 lookup misses after reset", {62'd0, v, h}, 64'h2);
  endtask

  task automatic t_regs;
    logic [31:0] d; logic v;
    wr(12'h004, 32'hA5A5_0002);
    rd(12'h004, d, v);
    check("R2 rvalid one cycle after strobe", 64'(v), 64'h1);
    check("R3 ctrl readback", 64'(d), 64'hA5A5_0002);
    wr(12'h030, 32'hFFFF_FFF3);
    rd(12'h030, d, v); check("R2 size keeps 3 bits", 64'(d), 64'h3);
    wr(lo_of(5), 32'h8000_0001); wr(hi_of(5), 32'h0000_0012);
    rd(lo_of(5), d, v); check("R3 window5 low readback", 64'(d), 64'h8000_0001);
    rd(hi_of(5), d, v); check("R3 window5 high readback", 64'(d), 64'h12);
    wr(lo_of(31), 32'hC000_0001); wr(hi_of(31), 32'h0);
    rd(lo_of(31), d, v); check("R3 window31 low readback", 64'(d), 64'hC000_0001);
  endtask

  task automatic t_basic;
    logic v, h; logic [63:0] r;
    wr(12'h030, 32'd3);
    wr(lo_of(0), 32'h9000_0001); wr(hi_of(0), 32'h0);
    xl(BASE + 32'h1234, v, h, r);
    check("R9 resp_valid two edges after request", 64'(v), 64'h1);
    check("R4 window0 hit", 64'(h), 64'h1);
    check("R7 window0 address", r, 64'h9000_1234);
  endtask

  task automatic t_index;
    logic v, h; logic [63:0] r;
    wr(lo_of(2), 32'hA000_0001); wr(hi_of(2), 32'h1);
    xl(BASE + 2*8*MB + 32'h10, v, h, r);
    check("R4 8MiB window2 address", r, 64'h1_A000_0010);
    wr(12'h030, 32'd0);
    xl(BASE + 2*MB + 32'h5, v, h, r);
    check("R4 1MiB window2 address", r, 64'h1_A000_0005);
    xl(BASE + 31*MB + 32'h1, v, h, r);
    check("R8 last window hits", {63'd0, h}, 64'h1);
    check("R7 last window address", r, 64'hC000_0001);
  endtask

  task automatic t_carry;
    logic v, h; logic [63:0] r;
    wr(12'h030, 32'd2);
    wr(lo_of(3), 32'hFFF0_0001); wr(hi_of(3), 32'h7);
    xl(BASE + 12*MB + 32'h20_0000, v, h, r);
    check("R7 carry into high word", r, 64'h8_0010_0000);
  endtask

  task automatic t_range;
    logic v, h; logic [63:0] r;
    wr(12'h030, 32'd0);
    xl(BASE + 32*MB, v, h, r);
    check("R8 window 32 misses", {62'd0, v, h}, 64'h2);
    check("R9 miss address zero", r, 64'h0);
    xl(BASE - 32'h4, v, h, r);
    check("R8 below base misses", {62'd0, v, h}, 64'h2);
  endtask

  task automatic t_win_off;
    logic v, h; logic [63:0] r;
    wr(lo_of(0), 32'h9000_0000);
    xl(BASE + 32'h40, v, h, r);
    check("R6 disabled window misses", {62'd0, v, h}, 64'h2);
    wr(lo_of(0), 32'h9000_0001);
    xl(BASE + 32'h40, v, h, r);
    check("R6 re-enabled window hits", r, 64'h9000_0040);
  endtask

  task automatic t_gen_off;
    logic v, h; logic [63:0] r;
    wr(12'h004, 32'h0);
    xl(BASE + 32'h40, v, h, r);
    check("R5 global off misses", {62'd0, v, h}, 64'h2);
    check("R9 global off address zero", r, 64'h0);
    wr(12'h004, 32'h2);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic v;
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d, v); check("R10 unmapped read zero", 64'(d), 64'h0);
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h004, d, v); check("R10 ctrl untouched", 64'(d), 64'h2);
    rd(12'h030, d, v); check("R10 size untouched", 64'(d), 64'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_basic();
    t_index();
    t_carry();
    t_range();
    t_win_off();
    t_gen_off();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule